// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status

This block watches a group of general-purpose input lines, which arrive already synchronized to its clock. It turns their activity into per-line interrupt events. Software sets up each line through byte-addressed registers. A line can be sensed by level or by edge, and polarity chooses active-high/rising or active-low/falling. A separate per-line select makes an edge-sensed line fire on either transition, and polarity is then ignored for that line.

Level events are not stored: a level line's raw status tracks the input while the condition holds. Edge events are captured in a per-line latch. The latch stays set until software writes a one to that line's bit in the clear register. Raw status is masked by a per-line enable to form masked status. All masked bits are ORed into one interrupt output. Register writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the sense, both-edge, polarity and enable registers all read 0. Raw status, masked status and `irq_o` are also 0. Every line therefore starts as falling-edge sensed and disabled.
- R2: With sense bit n = 1 (level), raw status bit n is 1 exactly while `pin_i[n]` equals polarity bit n. It returns to 0 as soon as the input leaves that level, and nothing is latched.
- R3: With sense bit n = 0 and both-edge bit n = 0, a rising transition sets raw bit n when polarity bit n = 1. A falling transition sets it when polarity bit n = 0. The opposite transition sets nothing. The bit stays set after the input returns.
- R4: With sense bit n = 0 and both-edge bit n = 1, either transition of `pin_i[n]` sets raw bit n, whatever the polarity bit holds.
- R5: Masked status equals raw status AND the enable register, and `irq_o` is the OR of all masked bits.
- R6: Writing the clear register (offset 0x41C) clears the latched edge event of each line whose data bit is 1. Lines whose data bit is 0 keep their state, and the clear register reads 0.
- R7: If a new qualifying edge on line n and a clear of line n fall in the same clock cycle, the new edge wins and raw bit n stays 1.
- R8: The byte offsets are: sense 0x404, both-edge 0x408, polarity 0x40C, enable 0x410 (all read/write), raw status 0x414 and masked status 0x418 (read-only). Line n is data bit n. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_LINES | Synchronized input lines |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | N_LINES | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | N_LINES | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An input transition and a software clear of the same line can hit the same clock edge. The outcome then depends on the priority in the edge latch. The bench provokes this by first latching a rising event on a line and letting the input fall. In one cycle it then raises the input again while writing that line's clear bit. Raw status must still show the event afterwards, so a design in which the clear takes priority reads 0 and is reported.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFF_W = 12;
  localparam logic [OFF_W-1:0] OFF_SENSE = 12'h404;
  localparam logic [OFF_W-1:0] OFF_BOTH  = 12'h408;
  localparam logic [OFF_W-1:0] OFF_POL   = 12'h40C;
  localparam logic [OFF_W-1:0] OFF_EN    = 12'h410;
  localparam logic [OFF_W-1:0] OFF_RAW   = 12'h414;
  localparam logic [OFF_W-1:0] OFF_MSK   = 12'h418;
  localparam logic [OFF_W-1:0] OFF_CLR   = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_BOTH, SEL_POL, SEL_EN, SEL_RAW, SEL_MSK, SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic               wr_en_i,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] sense_o,
  output logic [N_LINES-1:0] both_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] clr_o,
  output logic [N_LINES-1:0] rdata_o
);
  reg_sel_e sel;
  logic [N_LINES-1:0] sense_q, both_q, pol_q, en_q;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_SENSE): sel = SEL_SENSE;
      ADDR_W'(OFF_BOTH):  sel = SEL_BOTH;
      ADDR_W'(OFF_POL):   sel = SEL_POL;
      ADDR_W'(OFF_EN):    sel = SEL_EN;
      ADDR_W'(OFF_RAW):   sel = SEL_RAW;
      ADDR_W'(OFF_MSK):   sel = SEL_MSK;
      ADDR_W'(OFF_CLR):   sel = SEL_CLR;
      default:            sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_SENSE) sense_q <= wdata_i;
      if (sel == SEL_BOTH)  both_q  <= wdata_i;
      if (sel == SEL_POL)   pol_q   <= wdata_i;
      if (sel == SEL_EN)    en_q    <= wdata_i;
    end
  end

  assign clr_o = (wr_en_i && sel == SEL_CLR) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      SEL_SENSE: rdata_o = sense_q;
      SEL_BOTH:  rdata_o = both_q;
      SEL_POL:   rdata_o = pol_q;
      SEL_EN:    rdata_o = en_q;
      SEL_RAW:   rdata_o = raw_i;
      SEL_MSK:   rdata_o = raw_i & en_q;
      default:   rdata_o = '0;
    endcase
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign en_o    = en_q;

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(sense_q) && $stable(both_q) && $stable(pol_q) && $stable(en_q)));
  p_clr_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_CLR)) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pin_i,
  input  logic [N_LINES-1:0] sense_i,
  input  logic [N_LINES-1:0] both_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] raw_o
);
  logic [N_LINES-1:0] prev_q, lat_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic rise, fall;
    assign rise = pin_i[g] & ~prev_q[g];
    assign fall = ~pin_i[g] & prev_q[g];
    // either-edge select overrides polarity
    assign hit[g] = ~sense_i[g] & (both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall));

    // a fresh edge beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_q[g] <= 1'b0;
      else if (hit[g])   lat_q[g] <= 1'b1;
      else if (clr_i[g]) lat_q[g] <= 1'b0;
    end

    assign raw_o[g] = sense_i[g] ? (pin_i[g] == pol_i[g]) : lat_q[g];

    p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[g] |=> lat_q[g]);
    p_clr_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !hit[g]) |=> !lat_q[g]);
    p_level_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[g] && (pin_i[g] != pol_i[g])) |-> !raw_o[g]);
  end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic               wr_en_i,
  output logic [N_LINES-1:0] rdata_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] sense, both, pol, en, clr, raw;

  gpio_irq_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .raw_i(raw), .sense_o(sense), .both_o(both),
    .pol_o(pol), .en_o(en), .clr_o(clr), .rdata_o(rdata_o)
  );

  gpio_irq_detect #(.N_LINES(N_LINES)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sense_i(sense),
    .both_i(both), .pol_i(pol), .clr_i(clr), .raw_o(raw)
  );

  assign irq_o = |(raw & en);

  p_irq_off_when_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  p_irq_needs_raw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));
endmodule

// File: tb/gpio_irq_sense_test.sv
`timescale 1ns/1ps
module gpio_irq_sense_test;
  localparam int N = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_SENSE = 12'h404, A_BOTH = 12'h408, A_POL = 12'h40C,
    A_EN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418, A_CLR = 12'h41C;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [N-1:0] pin = '0, wdata = '0, rdata;
  logic [AW-1:0] addr = '0;
  logic irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gpio_irq_sense #(.N_LINES(N), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin[idx] = v;
    @(negedge clk);
  endtask

  task automatic cleanup();
    wr(A_SENSE, '0); wr(A_BOTH, '0); wr(A_POL, '0); wr(A_EN, '0);
    wr(A_CLR, '1);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    rd(A_SENSE, d); check("R1 sense", d, '0);
    rd(A_BOTH, d);  check("R1 both", d, '0);
    rd(A_POL, d);   check("R1 pol", d, '0);
    rd(A_EN, d);    check("R1 en", d, '0);
    rd(A_RAW, d);   check("R1 raw", d, '0);
    rd(A_MSK, d);   check("R1 masked", d, '0);
    check("R1 irq", {7'b0, irq}, '0);
  endtask

  task automatic t_regs();
    logic [N-1:0] d;
    wr(A_SENSE, 8'hA5); wr(A_BOTH, 8'h3C); wr(A_POL, 8'h96); wr(A_EN, 8'h00);
    rd(A_SENSE, d); check("R8 sense rb", d, 8'hA5);
    rd(A_BOTH, d);  check("R8 both rb", d, 8'h3C);
    rd(A_POL, d);   check("R8 pol rb", d, 8'h96);
    rd(A_EN, d);    check("R8 en rb", d, 8'h00);
    rd(12'h400, d); check("R8 unmapped", d, '0);
    rd(A_CLR, d);   check("R6 clr reads 0", d, '0);
    cleanup();
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(A_POL, 8'h01); wr(A_SENSE, 8'h03);
    set_pin(0, 1);
    rd(A_RAW, d); check("R2 level high+low active", d & 8'h03, 8'h03);
    set_pin(0, 0);
    rd(A_RAW, d); check("R2 high level drops", d & 8'h03, 8'h02);
    set_pin(1, 1);
    rd(A_RAW, d); check("R2 low level drops", d & 8'h03, 8'h00);
    set_pin(1, 0);
    cleanup();
  endtask

  task automatic t_edge();
    logic [N-1:0] d;
    wr(A_POL, 8'h04);
    set_pin(2, 1); set_pin(3, 1);
    rd(A_RAW, d); check("R3 rise latched, rise ignored on fall line", d & 8'h0C, 8'h04);
    set_pin(2, 0); set_pin(3, 0);
    rd(A_RAW, d); check("R3 hold and falling latched", d & 8'h0C, 8'h0C);
    cleanup();
  endtask

  task automatic t_both();
    logic [N-1:0] d;
    wr(A_BOTH, 8'h10);
    set_pin(4, 1);
    rd(A_RAW, d); check("R4 rise with pol=0", d & 8'h10, 8'h10);
    wr(A_CLR, 8'h10);
    rd(A_RAW, d); check("R6 cleared", d & 8'h10, 8'h00);
    set_pin(4, 0);
    rd(A_RAW, d); check("R4 fall", d & 8'h10, 8'h10);
    // leave line 4 latched for masking test
  endtask

  task automatic t_mask();
    logic [N-1:0] d;
    rd(A_MSK, d); check("R5 masked off", d, 8'h00);
    check("R5 irq off", {7'b0, irq}, 8'h00);
    wr(A_EN, 8'hEF);
    rd(A_MSK, d); check("R5 other lines enabled", d, 8'h00);
    check("R5 irq still off", {7'b0, irq}, 8'h00);
    wr(A_EN, 8'h10);
    rd(A_MSK, d); check("R5 masked on", d, 8'h10);
    check("R5 irq on", {7'b0, irq}, 8'h01);
    cleanup();
  endtask

  task automatic t_clear_sel();
    logic [N-1:0] d;
    wr(A_POL, 8'h04); wr(A_BOTH, 8'h10);
    set_pin(2, 1); set_pin(4, 1);
    wr(A_CLR, 8'h04);
    rd(A_RAW, d); check("R6 selective clear", d & 8'h14, 8'h10);
    set_pin(2, 0); set_pin(4, 0);
    cleanup();
  endtask

  task automatic t_race();
    logic [N-1:0] d;
    wr(A_POL, 8'h20);
    set_pin(5, 1);
    set_pin(5, 0);
    rd(A_RAW, d); check("R7 pre latched", d & 8'h20, 8'h20);
    @(negedge clk);
    pin[5] = 1; addr = A_CLR; wdata = 8'h20; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wdata = '0;
    rd(A_RAW, d); check("R7 edge beats clear", d & 8'h20, 8'h20);
    wr(A_CLR, 8'h20);
    rd(A_RAW, d); check("R6 clear after race", d & 8'h20, 8'h00);
    set_pin(5, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_clear_sel();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule